// File: doc/BRIEF.md
# Programmable ROM mode controller

This block is a synthesizable, clocked model of a byte-wide ultraviolet-erasable programmable ROM. Five control inputs are decoded into one of seven operating modes: read, output disable, standby, program, program verify, program inhibit and identification. The decoded mode sets whether the byte array is written, whether the data bus is driven, and what is driven onto it. Analog conditions become single-bit flags: a raised program supply and a high voltage on address bit 9. Ultraviolet erasure becomes a one-cycle erase request that sets every location to all ones.

The storage array is held in registers. Its depth is a parameter, so the array can be much shallower than the full 17-bit address space. Only the low address bits that index the array are used, and the upper bits alias.

Outputs are registered. The bus state produced by one cycle's inputs appears after the next rising clock edge. Data-bus direction is given by a separate output-enable signal, so the block can sit behind a tristate pad or a bus multiplexer.

Top module: `prom_ctrl_top`

## Requirements
- R1: While reset is asserted and after it is released, every array location reads 0xFF and `dataOe` is 0 until a driving mode is applied.
- R2: Read mode has `ceN`=0, `oeN`=0 and `vppHigh`=0, without the identification condition of R8. After the next rising edge, `dataOe` is 1 and `dataOut` equals the byte stored at the low address bits.
- R3: With `ceN`=0, `oeN`=1 and `vppHigh`=0 (output disable), `dataOe` is 0 after the next edge, and the array is unchanged.
- R4: With `ceN`=1 and `vppHigh`=0 (standby), `dataOe` is 0 after the next edge whatever `oeN`, `progN` and `idHigh` are, and nothing is written.
- R5: Program mode has `ceN`=0, `oeN`=1, `vppHigh`=1 and `progN`=0. Each such cycle replaces the addressed byte with its old value ANDed with `dataIn`, so bits can only be cleared. `dataOe` is 0.
- R6: Program verify has `ceN`=0, `oeN`=0, `progN`=1 and `vppHigh`=1. It drives the stored byte exactly as R2 does and writes nothing.
- R7: With `ceN`=1 and `vppHigh`=1 (program inhibit), `dataOe` is 0 and nothing is written, even while `progN` is 0.
- R8: Identification mode has `ceN`=0, `oeN`=0, `progN`=1, `idHigh`=1 and `vppHigh`=0. It drives code 0x20 when address bit 0 is 0 and 0x05 when it is 1, whatever the array holds.
- R9: A cycle with `eraseAll`=1 sets every location to 0xFF by the next edge, and it overrides a program write made in the same cycle.
- R10: The remaining combinations with `ceN`=0 and `vppHigh`=1 are `oeN`=1 with `progN`=1, and `oeN`=0 with `progN`=0. Both act as output disable: `dataOe` is 0 and nothing is written.
- R11: Address bits at and above log2(DEPTH) are ignored. An address and the same address plus DEPTH select the same location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset; fills the array with 0xFF |
| addr | input | ADDR_W (17) | Byte address; bit 0 also picks the identification code |
| dataIn | input | DATA_W (8) | Byte applied during program mode |
| dataOut | output | DATA_W (8) | Byte driven onto the bus when `dataOe` is 1 |
| dataOe | output | 1 | 1 when the block drives the data bus |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| progN | input | 1 | Program strobe, active low |
| vppHigh | input | 1 | Program supply raised |
| idHigh | input | 1 | High voltage present on address bit 9 |
| eraseAll | input | 1 | Erase request; sets the whole array to 0xFF |

## Verification
The bench builds the block with DEPTH set to 16, so every location can be read, programmed twice and read back in a few hundred cycles. With four array index bits it also reaches the aliasing of R11 through addresses that differ only above bit 3. All 32 combinations of the five control flags are swept at varying addresses. A read-back after each one shows whether a write took place, so all seven modes and both groups of leftover combinations are reached against a bench-side copy of the array.

// File: rtl/prom_pkg.sv
package prom_pkg;

  typedef enum logic [2:0] {
    MODE_STANDBY,
    MODE_INHIBIT,
    MODE_READ,
    MODE_OUTDIS,
    MODE_PROGRAM,
    MODE_VERIFY,
    MODE_IDENT,
    MODE_UNLISTED
  } promMode_e;

  typedef struct packed {
    logic eraseAll;
    logic writeByte;
    logic driveArray;
    logic driveIdent;
  } promStrobe_t;

endpackage

// File: rtl/prom_mode_decode.sv
module prom_mode_decode
  import prom_pkg::*;
(
  input  logic        ceN,
  input  logic        oeN,
  input  logic        progN,
  input  logic        vppHigh,
  input  logic        idHigh,
  input  logic        eraseReq,
  output promStrobe_t strobe
);

  promMode_e mode;

  // Mode decode: chip enable first, then supply level, then the output and program controls
  always_comb begin
    if (ceN) begin
      mode = vppHigh ? MODE_INHIBIT : MODE_STANDBY;
    end else if (!vppHigh) begin
      if (oeN)                 mode = MODE_OUTDIS;
      else if (idHigh && progN) mode = MODE_IDENT;
      else                     mode = MODE_READ;
    end else begin
      case ({oeN, progN})
        2'b10:   mode = MODE_PROGRAM;
        2'b01:   mode = MODE_VERIFY;
        default: mode = MODE_UNLISTED;
      endcase
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.eraseAll = eraseReq;
    case (mode)
      MODE_READ,
      MODE_VERIFY:  strobe.driveArray = 1'b1;
      MODE_IDENT:   strobe.driveIdent = 1'b1;
      MODE_PROGRAM: strobe.writeByte  = 1'b1;
      default:      ;
    endcase
  end

endmodule

// File: rtl/prom_array_dp.sv
module prom_array_dp
  import prom_pkg::*;
#(
  parameter int          DEPTH    = 256,
  parameter int          DATA_W   = 8,
  parameter logic [7:0]  MFR_CODE = 8'h20,
  parameter logic [7:0]  DEV_CODE = 8'h05,
  localparam int         IDX_W    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  promStrobe_t       strobe,
  input  logic [IDX_W-1:0]  idx,
  input  logic              addrLsb,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] storedByte;
  logic [DATA_W-1:0] clearedByte;
  logic [DATA_W-1:0] idCode;

  assign storedByte  = mem[idx];
  assign clearedByte = storedByte & dataIn;
  assign idCode      = addrLsb ? DATA_W'(DEV_CODE) : DATA_W'(MFR_CODE);

  // Array: reset and erase fill with ones; programming only clears bits
  always_ff @(posedge clk) begin
    if (!rstN || strobe.eraseAll) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (strobe.writeByte) begin
      mem[idx] <= clearedByte;
    end
  end

  // Registered bus side
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataOut <= '0;
      dataOe  <= 1'b0;
    end else begin
      dataOe <= strobe.driveArray | strobe.driveIdent;
      if (strobe.driveIdent)      dataOut <= idCode;
      else if (strobe.driveArray) dataOut <= storedByte;
      else                        dataOut <= '0;
    end
  end

endmodule

// File: rtl/prom_ctrl_top.sv
module prom_ctrl_top
  import prom_pkg::*;
#(
  parameter int          ADDR_W   = 17,
  parameter int          DATA_W   = 8,
  parameter int          DEPTH    = 256,
  parameter logic [7:0]  MFR_CODE = 8'h20,
  parameter logic [7:0]  DEV_CODE = 8'h05,
  localparam int         IDX_W    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              progN,
  input  logic              vppHigh,
  input  logic              idHigh,
  input  logic              eraseAll
);

  promStrobe_t strobe;

  // Address bits above the array index alias onto the array
  generate
    if (IDX_W < ADDR_W) begin : g_alias
      logic unusedHighAddr;
      assign unusedHighAddr = ^addr[ADDR_W-1:IDX_W];
    end
  endgenerate

  prom_mode_decode u_decode (
    .ceN      (ceN),
    .oeN      (oeN),
    .progN    (progN),
    .vppHigh  (vppHigh),
    .idHigh   (idHigh),
    .eraseReq (eraseAll),
    .strobe   (strobe)
  );

  prom_array_dp #(
    .DEPTH    (DEPTH),
    .DATA_W   (DATA_W),
    .MFR_CODE (MFR_CODE),
    .DEV_CODE (DEV_CODE)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .idx     (addr[IDX_W-1:0]),
    .addrLsb (addr[0]),
    .dataIn  (dataIn),
    .dataOut (dataOut),
    .dataOe  (dataOe)
  );

endmodule

// File: rtl/prom_ctrl_chk.sv
module prom_ctrl_chk #(
  parameter int         DATA_W   = 8,
  parameter logic [7:0] MFR_CODE = 8'h20,
  parameter logic [7:0] DEV_CODE = 8'h05
) (
  input logic              clk,
  input logic              rstN,
  input logic              ceN,
  input logic              oeN,
  input logic              progN,
  input logic              vppHigh,
  input logic              idHigh,
  input logic              addrLsb,
  input logic [DATA_W-1:0] dataOut,
  input logic              dataOe
);

  assert_standby_hiz_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ceN && !vppHigh) |=> !dataOe);

  assert_inhibit_hiz_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ceN && vppHigh) |=> !dataOe);

  assert_outdis_hiz_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && oeN) |=> !dataOe);

  assert_read_drives_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && !oeN && !vppHigh) |=> dataOe);

  assert_verify_drives_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && !oeN && progN && vppHigh) |=> dataOe);

  assert_unlisted_hiz_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && !oeN && !progN && vppHigh) |=> !dataOe);

  assert_mfr_code_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && !oeN && progN && idHigh && !vppHigh && !addrLsb)
      |=> (dataOut == DATA_W'(MFR_CODE)));

  assert_dev_code_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && !oeN && progN && idHigh && !vppHigh && addrLsb)
      |=> (dataOut == DATA_W'(DEV_CODE)));

endmodule

bind prom_ctrl_top prom_ctrl_chk #(
  .DATA_W   (DATA_W),
  .MFR_CODE (MFR_CODE),
  .DEV_CODE (DEV_CODE)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .ceN     (ceN),
  .oeN     (oeN),
  .progN   (progN),
  .vppHigh (vppHigh),
  .idHigh  (idHigh),
  .addrLsb (addr[0]),
  .dataOut (dataOut),
  .dataOe  (dataOe)
);

// File: tb/prom_ctrl_top_test.sv
`timescale 1ns/1ps
module prom_ctrl_top_test;

  localparam int ADDR_W = 17;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 16;

  logic              clk = 1'b0;
  logic              rstN;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] dataIn;
  logic [DATA_W-1:0] dataOut;
  logic              dataOe;
  logic              ceN, oeN, progN, vppHigh, idHigh, eraseAll;

  int compared   = 0;
  int mismatched = 0;
  bit finished   = 0;

  logic [7:0] expMem [DEPTH];

  always #2.5 clk = ~clk;

  prom_ctrl_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .addr(addr), .dataIn(dataIn),
    .dataOut(dataOut), .dataOe(dataOe), .ceN(ceN), .oeN(oeN),
    .progN(progN), .vppHigh(vppHigh), .idHigh(idHigh), .eraseAll(eraseAll)
  );

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  task automatic chk8(string tag, logic [7:0] act, logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic chk1(string tag, logic act, logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  // One cycle: drive after the falling edge, sample just after the rising edge
  task automatic cyc(logic c, logic o, logic p, logic v, logic i,
                     logic [ADDR_W-1:0] a, logic [7:0] d, logic e);
    @(negedge clk);
    ceN = c; oeN = o; progN = p; vppHigh = v; idHigh = i;
    addr = a; dataIn = d; eraseAll = e;
    @(posedge clk);
    #1;
  endtask

  task automatic readBack(int loc, logic [ADDR_W-1:0] hi, string tag);
    cyc(0, 0, 1, 0, 0, hi | ADDR_W'(loc), 8'h00, 0);
    chk1(tag, dataOe, 1'b1);
    chk8(tag, dataOut, expMem[loc]);
  endtask

  // Expected behaviour class: 0 = quiet, 1 = drive array, 2 = drive id code, 3 = program
  function automatic int kindOf(logic c, logic o, logic p, logic v, logic i);
    if (c) return 0;
    if (!v) begin
      if (o) return 0;
      return (i && p) ? 2 : 1;
    end
    if (o) return p ? 0 : 3;
    return p ? 1 : 0;
  endfunction

  function automatic string tagOf(logic c, logic o, logic p, logic v, logic i);
    if (c) return v ? "R7" : "R4";
    if (!v) begin
      if (o) return "R3";
      return (i && p) ? "R8" : "R2";
    end
    if (o) return p ? "R10" : "R5";
    return p ? "R6" : "R10";
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    rstN = 0; ceN = 1; oeN = 1; progN = 1; vppHigh = 0; idHigh = 0;
    addr = '0; dataIn = '0; eraseAll = 0;
    repeat (3) @(posedge clk);
    #1;
    chk1("R1 reset oe", dataOe, 1'b0);
    @(negedge clk);
    rstN = 1;
    @(posedge clk);
    #1;
    chk1("R1 after reset oe", dataOe, 1'b0);
    for (int k = 0; k < DEPTH; k++) expMem[k] = 8'hFF;
    for (int k = 0; k < DEPTH; k++) readBack(k, '0, "R1 erased");

    // Program every location twice: bits only clear (R5), read and verify back
    for (int k = 0; k < DEPTH; k++) begin
      logic [7:0] p1, p2;
      p1 = 8'hFF ^ 8'((k * 29) + 3);
      p2 = 8'hFF ^ 8'(k << 2);
      cyc(0, 1, 0, 1, 0, ADDR_W'(k), p1, 0);
      chk1("R5 program oe", dataOe, 1'b0);
      cyc(0, 1, 0, 1, 0, ADDR_W'(k), p2, 0);
      expMem[k] = 8'hFF & p1 & p2;
    end
    for (int k = 0; k < DEPTH; k++) readBack(k, '0, "R5 R2 programmed");
    for (int k = 0; k < DEPTH; k++) begin
      cyc(0, 0, 1, 1, 0, ADDR_W'(k), 8'h00, 0);
      chk1("R6 verify oe", dataOe, 1'b1);
      chk8("R6 verify data", dataOut, expMem[k]);
    end

    // Exhaustive sweep of the five control flags
    for (int rep = 0; rep < 2; rep++) begin
      for (int cmb = 0; cmb < 32; cmb++) begin
        logic c, o, p, v, i;
        int loc, kd;
        logic [ADDR_W-1:0] a;
        logic [7:0] d;
        {c, o, p, v, i} = 5'(cmb);
        loc = (cmb * 5 + rep * 3) % DEPTH;
        a   = ADDR_W'(loc) | (ADDR_W'(cmb + rep) << 4);
        d   = 8'(8'hF3 ^ (cmb << 3) ^ rep);
        kd  = kindOf(c, o, p, v, i);
        cyc(c, o, p, v, i, a, d, 0);
        chk1(tagOf(c, o, p, v, i), dataOe, (kd == 1 || kd == 2));
        if (kd == 1) chk8(tagOf(c, o, p, v, i), dataOut, expMem[loc]);
        if (kd == 2) chk8("R8 id code", dataOut, a[0] ? 8'h05 : 8'h20);
        if (kd == 3) expMem[loc] = expMem[loc] & d;
        readBack(loc, '0, tagOf(c, o, p, v, i));
      end
    end

    // Identification ignores array contents, at every address
    for (int k = 0; k < DEPTH; k++) begin
      cyc(0, 0, 1, 0, 1, ADDR_W'(k) | 17'h10000, 8'h00, 0);
      chk8("R8 id sweep", dataOut, k[0] ? 8'h05 : 8'h20);
    end

    // Aliasing: program through an address above the array depth
    cyc(0, 1, 0, 1, 0, ADDR_W'(DEPTH + 6), 8'h3C, 0);
    expMem[6] = expMem[6] & 8'h3C;
    readBack(6, '0, "R11 alias low");
    readBack(6, ADDR_W'(DEPTH * 9), "R11 alias high");

    // Erase wins over a simultaneous program write
    cyc(0, 1, 0, 1, 0, ADDR_W'(2), 8'h00, 1);
    for (int k = 0; k < DEPTH; k++) expMem[k] = 8'hFF;
    for (int k = 0; k < DEPTH; k++) readBack(k, '0, "R9 erase");

    report();
  end

endmodule